// File: doc/BRIEF.md
# Four-bit function-select arithmetic-logic slice

This block is a purely combinational arithmetic-logic slice. It takes two operand words, a four-bit function code, a mode bit and a carry input. It returns a result word and a carry output. When the mode bit is high, the slice applies one of sixteen bitwise functions of the two operands and ignores the carry input. When the mode bit is low, the slice forms one of sixteen sums. Each sum has the form X + Y + carry. The first addend X is picked by the low two bits of the function code and the second addend Y by the high two bits.

The slice also drives an all-ones flag on the result, which works as an equality comparator when the slice subtracts. It drives a group generate and a group propagate so that an external lookahead unit can chain several slices. The carry input is active high: a 1 adds one to the sum.

Top module: `alu_slice`

## Requirements
- R1: With `i_logic`=1, `o_f` depends only on the operands and the code, as follows per bit:
  - 0 gives ~A, 1 gives ~(A&B), 2 gives ~A|B, 3 gives all ones.
  - 4 gives ~(A|B), 5 gives ~B, 6 gives ~(A^B), 7 gives A|~B.
  - 8 gives ~A&B, 9 gives A^B, 10 gives B, 11 gives A|B.
  - 12 gives zero, 13 gives A&~B, 14 gives A&B, 15 gives A.
  - `i_cin` has no effect on the result.
- R2: With `i_logic`=1, `o_cout` is 0 for every input.
- R3: With `i_logic`=0, code 6 gives A−B−1 when `i_cin`=0 and A−B when `i_cin`=1. Code 9 gives A+B+`i_cin`. Results are taken modulo 2^W.
- R4: With `i_logic`=0, further codes give the following (a 1 on `i_cin` adds one to each):
  - Code 0 gives A−1.
  - Code 3 gives all ones.
  - Code 12 gives A+A.
  - Code 15 gives A.
- R5: With `i_logic`=0, the remaining codes give the following, each plus `i_cin`:
  - 1 gives (A&B)−1, 2 gives (A&~B)−1.
  - 4 gives A+(A|~B), 5 gives (A&B)+(A|~B), 7 gives A|~B.
  - 8 gives A+(A|B), 10 gives (A&~B)+(A|B), 11 gives A|B.
  - 13 gives (A&B)+A, 14 gives (A&~B)+A.
- R6: With `i_logic`=0, `o_cout` is the bit above the MSB of the full sum. For example, code 0 with `i_cin`=0 sets `o_cout` exactly when A≠0.
- R7: `o_eq` is 1 exactly when `o_f` is all ones. With `i_logic`=0, code 6 and `i_cin`=0, `o_eq` equals (A==B).
- R8: With `i_logic`=0, `o_gen` equals the carry output the slice gives for the same code and operands when `i_cin`=0.
- R9: With `i_logic`=0, `o_cout` equals `o_gen | (o_prop & i_cin)`, and `o_gen|o_prop` equals the carry output for `i_cin`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_a | input | W | Operand A |
| i_b | input | W | Operand B |
| i_sel | input | 4 | Function code |
| i_logic | input | 1 | 1 selects bitwise functions, 0 selects sums |
| i_cin | input | 1 | Carry input, 1 adds one |
| o_f | output | W | Result |
| o_cout | output | 1 | Carry output of the sum, 0 in bitwise mode |
| o_eq | output | 1 | Result is all ones |
| o_gen | output | 1 | Group generate |
| o_prop | output | 1 | Group propagate |

## Verification
The checker tests several relations on every change of the inputs:
- the carry output is zero in bitwise mode;
- the carry output agrees with the group generate and propagate combined with the carry input;
- the comparator matches operand equality on the subtract code;
- the add code and two bitwise codes are checked against direct operand arithmetic.

The bench sweeps every operand pair, every code, both modes and both carry values. This full sweep is the only thing that shows the remaining sum formulas and the bitwise functions are right. It also shows that the carry input is ignored in bitwise mode and that the group generate matches the carry-free carry out.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    // First addend choice, taken from the low two code bits
    typedef enum logic [1:0] {
        XA_OPA    = 2'd0,
        XA_AND    = 2'd1,
        XA_ANDNB  = 2'd2,
        XA_ZERO   = 2'd3
    } xadd_e;

    // Second addend choice, taken from the high two code bits
    typedef enum logic [1:0] {
        YA_ONES   = 2'd0,
        YA_ORNB   = 2'd1,
        YA_OR     = 2'd2,
        YA_OPA    = 2'd3
    } yadd_e;

    // Per-bit truth table of a bitwise function, indexed by {a,b}
    function automatic logic [3:0] logic_truth(input logic [3:0] code);
        logic [3:0] tt;
        case (code)
            4'd0:    tt = 4'b0011; // ~A
            4'd1:    tt = 4'b0111; // ~(A&B)
            4'd2:    tt = 4'b1011; // ~A|B
            4'd3:    tt = 4'b1111; // ones
            4'd4:    tt = 4'b0001; // ~(A|B)
            4'd5:    tt = 4'b0101; // ~B
            4'd6:    tt = 4'b1001; // xnor
            4'd7:    tt = 4'b1101; // A|~B
            4'd8:    tt = 4'b0010; // ~A&B
            4'd9:    tt = 4'b0110; // xor
            4'd10:   tt = 4'b1010; // B
            4'd11:   tt = 4'b1110; // A|B
            4'd12:   tt = 4'b0000; // zero
            4'd13:   tt = 4'b0100; // A&~B
            4'd14:   tt = 4'b1000; // A&B
            default: tt = 4'b1100; // A
        endcase
        return tt;
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import alu_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   sel,
    output logic [W-1:0] x,
    output logic [W-1:0] y
);
    xadd_e xk;
    yadd_e yk;

    assign xk = xadd_e'(sel[1:0]);
    assign yk = yadd_e'(sel[3:2]);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (xk)
                XA_OPA:   x[i] = a[i];
                XA_AND:   x[i] = a[i] & b[i];
                XA_ANDNB: x[i] = a[i] & ~b[i];
                default:  x[i] = 1'b0;
            endcase
            unique case (yk)
                YA_ONES:  y[i] = 1'b1;
                YA_ORNB:  y[i] = a[i] | ~b[i];
                YA_OR:    y[i] = a[i] | b[i];
                default:  y[i] = a[i];
            endcase
        end
    end
endmodule

// File: rtl/alu_carry_net.sv
module alu_carry_net #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         grp_g,
    output logic         grp_p
);
    logic [W-1:0] gen_b;
    logic [W-1:0] prop_b;
    logic [W:0]   carry;
    logic [W:0]   g_acc;

    assign carry[0] = cin;
    assign g_acc[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign gen_b[i]    = x[i] & y[i];
        assign prop_b[i]   = x[i] ^ y[i];
        assign sum[i]      = prop_b[i] ^ carry[i];
        assign carry[i+1]  = gen_b[i] | (prop_b[i] & carry[i]);
        assign g_acc[i+1]  = gen_b[i] | (prop_b[i] & g_acc[i]);
    end

    assign cout  = carry[W];
    assign grp_g = g_acc[W];
    assign grp_p = &prop_b;
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   sel,
    output logic [W-1:0] f
);
    logic [3:0] tt;

    assign tt = logic_truth(sel);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign f[i] = tt[{a[i], b[i]}];
    end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] i_a,
    input  logic [W-1:0] i_b,
    input  logic [3:0]   i_sel,
    input  logic         i_logic,
    input  logic         i_cin,
    output logic [W-1:0] o_f,
    output logic         o_cout,
    output logic         o_eq,
    output logic         o_gen,
    output logic         o_prop
);
    typedef struct packed {
        logic [W-1:0] f;
        logic         cout;
        logic         eq;
    } res_t;

    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic [W-1:0] log_f;
    res_t         res_d;

    alu_operand_sel #(.W(W)) u_opsel (
        .a   (i_a),
        .b   (i_b),
        .sel (i_sel),
        .x   (add_x),
        .y   (add_y)
    );

    alu_carry_net #(.W(W)) u_carry (
        .x     (add_x),
        .y     (add_y),
        .cin   (i_cin),
        .sum   (add_sum),
        .cout  (add_cout),
        .grp_g (o_gen),
        .grp_p (o_prop)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .a   (i_a),
        .b   (i_b),
        .sel (i_sel),
        .f   (log_f)
    );

    always_comb begin
        res_d = '0;
        if (i_logic) begin
            res_d.f    = log_f;
            res_d.cout = 1'b0;
        end else begin
            res_d.f    = add_sum;
            res_d.cout = add_cout;
        end
        res_d.eq = &res_d.f;
    end

    assign o_f    = res_d.f;
    assign o_cout = res_d.cout;
    assign o_eq   = res_d.eq;
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] i_a,
    input logic [W-1:0] i_b,
    input logic [3:0]   i_sel,
    input logic         i_logic,
    input logic         i_cin,
    input logic [W-1:0] o_f,
    input logic         o_cout,
    input logic         o_eq,
    input logic         o_gen,
    input logic         o_prop
);
    logic [W:0] ab_sum;
    assign ab_sum = {1'b0, i_a} + {1'b0, i_b} + {{W{1'b0}}, i_cin};

    always_comb begin
        if (i_logic) begin
            p_logic_nocarry_r2: assert (!o_cout)
                else $error("bitwise mode drove carry out");
        end
        if (!i_logic) begin
            p_cascade_r9: assert (o_cout == (o_gen | (o_prop & i_cin)))
                else $error("carry out disagrees with group terms");
        end
        if (!i_logic && i_sel == 4'd6 && !i_cin) begin
            p_compare_r7: assert (o_eq == (i_a == i_b))
                else $error("comparator wrong");
        end
        if (!i_logic && i_sel == 4'd9) begin
            p_add_r3: assert ({o_cout, o_f} == ab_sum)
                else $error("add code wrong");
        end
        if (i_logic && i_sel == 4'd9) begin
            p_xor_r1: assert (o_f == (i_a ^ i_b))
                else $error("xor code wrong");
        end
        if (i_logic && i_sel == 4'd14) begin
            p_and_r1: assert (o_f == (i_a & i_b))
                else $error("and code wrong");
        end
    end
endmodule

bind alu_slice alu_slice_chk #(.W(W)) u_chk (
    .i_a     (i_a),
    .i_b     (i_b),
    .i_sel   (i_sel),
    .i_logic (i_logic),
    .i_cin   (i_cin),
    .o_f     (o_f),
    .o_cout  (o_cout),
    .o_eq    (o_eq),
    .o_gen   (o_gen),
    .o_prop  (o_prop)
);

// File: tb/alu_slice_tb_top.sv
module alu_slice_tb_top;
    localparam int W = 4;
    localparam int CLK_PERIOD = 10;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic [W-1:0] a, b, f;
    logic [3:0]   sel;
    logic         lmode, cin, cout, eq, gen, prop;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_slice #(.W(W)) dut_i (
        .i_a(a), .i_b(b), .i_sel(sel), .i_logic(lmode), .i_cin(cin),
        .o_f(f), .o_cout(cout), .o_eq(eq), .o_gen(gen), .o_prop(prop)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s sel=%0d m=%0d cin=%0d a=%0d b=%0d act=%0d exp=%0d",
                     req, sel, lmode, cin, a, b, act, exp);
        end
    endtask

    // Full-width arithmetic reference, written from the requirement formulas
    function automatic int arith_ref(input int s, input int x, input int y, input int c);
        int nb;
        nb = (~y) & MASK;
        case (s)
            0:  return x + MASK + c;             // R4 A-1
            1:  return (x & y) + MASK + c;       // R5
            2:  return (x & nb) + MASK + c;      // R5
            3:  return MASK + c;                 // R4
            4:  return x + (x | nb) + c;         // R5
            5:  return (x & y) + (x | nb) + c;   // R5
            6:  return x + nb + c;               // R3 A-B-1
            7:  return (x | nb) + c;             // R5
            8:  return x + (x | y) + c;          // R5
            9:  return x + y + c;                // R3
            10: return (x & nb) + (x | y) + c;   // R5
            11: return (x | y) + c;              // R5
            12: return x + x + c;                // R4
            13: return (x & y) + x + c;          // R5
            14: return (x & nb) + x + c;         // R5
            default: return x + c;               // R4
        endcase
    endfunction

    function automatic int logic_ref(input int s, input int x, input int y);
        int nx, ny;
        nx = (~x) & MASK;
        ny = (~y) & MASK;
        case (s)
            0:  return nx;
            1:  return (~(x & y)) & MASK;
            2:  return nx | y;
            3:  return MASK;
            4:  return (~(x | y)) & MASK;
            5:  return ny;
            6:  return (~(x ^ y)) & MASK;
            7:  return x | ny;
            8:  return nx & y;
            9:  return x ^ y;
            10: return y;
            11: return x | y;
            12: return 0;
            13: return x & ny;
            14: return x & y;
            default: return x;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; sel = '0; lmode = 1'b0; cin = 1'b0;
        @(negedge clk);
        // idle inputs: code 0 sum of zero operands is all ones, carry 0 (R4, R6)
        check("R4", f, MASK);
        check("R6", cout, 0);
        check("R7", eq, 1);

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 16; s++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int x = 0; x <= MASK; x++) begin
                        for (int y = 0; y <= MASK; y++) begin
                            @(posedge clk);
                            lmode = m[0]; sel = s[3:0]; cin = c[0];
                            a = x[W-1:0]; b = y[W-1:0];
                            @(negedge clk);
                            if (m == 1) begin
                                int e;
                                e = logic_ref(s, x, y);
                                check("R1", f, e);
                                check("R2", cout, 0);
                                check("R7", eq, (e == MASK) ? 1 : 0);
                            end else begin
                                int r, r0, r1;
                                r  = arith_ref(s, x, y, c);
                                r0 = arith_ref(s, x, y, 0);
                                r1 = arith_ref(s, x, y, 1);
                                if (s == 6 || s == 9)
                                    check("R3", f, r & MASK);
                                else if (s == 0 || s == 3 || s == 12 || s == 15)
                                    check("R4", f, r & MASK);
                                else
                                    check("R5", f, r & MASK);
                                check("R6", cout, (r >> W) & 1);
                                check("R7", eq, ((r & MASK) == MASK) ? 1 : 0);
                                if (s == 6 && c == 0)
                                    check("R7", eq, (x == y) ? 1 : 0);
                                check("R8", gen, (r0 >> W) & 1);
                                check("R9", gen | prop, (r1 >> W) & 1);
                            end
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule